// File: doc/BRIEF.md
# Slow Peripheral Bus Adapter

This block lets a fast master, whose bus cycles are framed by an address strobe, reach slow peripherals that only move data on a free-running slow clock. The adapter divides the system clock by ten to make that slow clock. The slow clock spends six input clocks low and four high. When the master runs a cycle and the address decoder marks it as a slow-peripheral access, the adapter waits for a suitable point in the low phase. It then raises its slot-valid output so the peripheral can take part. The adapter ends the cycle by itself: it sends a one-cycle completion pulse back to the master when the slow clock falls after the high phase in which the data moved.

The slow clock never stops. Slot-valid is raised only early enough in a low phase to give the peripheral a setup margin before the rising edge. A request that arrives too late in a low phase waits for the next low phase. The master may drop its strobe before slot-valid rises, and then the request is withdrawn. The transfer direction is captured when the adapter accepts the request, and it is presented alongside slot-valid.

Top module: `periph_bus_adapter`

## Requirements
- R1: The slow clock `sclk_o` runs without pause with a period of 10 clocks: 6 clocks low, then 4 clocks high.
- R2: While `rst` is high, `sclk_o`, `slot_valid_o` and `xfer_done_o` are 0. The divider restarts, so the first clock after reset is phase 0 and `sclk_o` first goes high 6 clocks later.
- R3: A request is accepted only in a clock where `strobe_i` and `slow_sel_i` are both 1. With `slow_sel_i` at 0, `slot_valid_o` never rises.
- R4: Phases are counted from reset, with phase 0 being the first low clock of a period. A pending request raises `slot_valid_o` on the edge after a clock with phase 0 to 3. `slot_valid_o` therefore always has at least 2 clocks of `sclk_o` low before the rise. A request accepted in phase 4 or later first raises `slot_valid_o` in phase 1 of the next period.
- R5: `slot_valid_o` stays high until the falling edge of `sclk_o` that ends the next high phase. On that edge `slot_valid_o` drops and `xfer_done_o` is high for exactly one clock.
- R6: If `strobe_i` is 0 in any clock after a request is accepted and before `slot_valid_o` rises, the request is dropped. No slot-valid and no completion follow.
- R7: `slot_write_o` takes the value of `write_i` in the clock in which the request is accepted. It holds that value while `slot_valid_o` is high, whatever `write_i` does later.
- R8: A master may drop its strobe in the clock of the completion and raise it again in the next clock, which is phase 1. That new request completes exactly 10 clocks after the previous one, so it uses the next slow-clock pulse.
- R9: A strobe still high in the clock in which `xfer_done_o` is 1 does not start a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_i | input | 1 | Master address strobe, active high |
| write_i | input | 1 | Master direction, 1 = write |
| slow_sel_i | input | 1 | Decoder mark for a slow-peripheral address |
| sclk_o | output | 1 | Slow clock, system clock divided by 10 |
| slot_valid_o | output | 1 | Peripheral access is valid in this slow-clock period |
| slot_write_o | output | 1 | Captured direction of the current access |
| xfer_done_o | output | 1 | One-clock completion pulse to the master |

## Verification
A divider that slips shows on `sclk_o` within one period, as a low or high run of the wrong length. A wrong launch window shows at the next accepted request: `slot_valid_o` rises in a phase other than the one predicted from the clocks counted since reset. A controller stuck in the wait or active state shows as a missing or extra completion pulse within ten clocks. It also shows as a slot-valid that appears after the strobe was withdrawn. A wrongly captured direction shows on `slot_write_o` during the first clock of the access.

// File: rtl/psb_pkg.sv
package psb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACT  = 2'd2
  } psb_state_e;
endpackage

// File: rtl/psb_clkdiv.sv
// Free-running divider producing the slow clock and the phase decodes
// the slot controller needs.
module psb_clkdiv #(
  parameter int DIV   = 10,
  parameter int HIGH  = 4,
  parameter int SETUP = 2
) (
  input  logic clk,
  input  logic rst,
  output logic sclk_o,
  output logic launch_ok_o,
  output logic wrap_o
);
  localparam int PW         = $clog2(DIV);
  localparam int LOW        = DIV - HIGH;
  localparam int LAUNCH_MAX = LOW - SETUP - 1;
  localparam logic [PW-1:0] LAST_P   = PW'(DIV - 1);
  localparam logic [PW-1:0] LOW_P    = PW'(LOW);
  localparam logic [PW-1:0] LAUNCH_P = PW'(LAUNCH_MAX);

  logic [PW-1:0] phase_q;
  logic [PW-1:0] phase_nxt;

  always_comb begin
    if (phase_q == LAST_P) phase_nxt = '0;
    else                   phase_nxt = phase_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      sclk_o  <= 1'b0;
    end else begin
      phase_q <= phase_nxt;
      sclk_o  <= (phase_nxt >= LOW_P);
    end
  end

  // launching now leaves at least SETUP low clocks of slot-valid
  assign launch_ok_o = (phase_q <= LAUNCH_P);
  assign wrap_o      = (phase_q == LAST_P);
endmodule

// File: rtl/psb_slot_ctl.sv
// Request acceptance, phase alignment and completion of one access.
module psb_slot_ctl
  import psb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic strobe_i,
  input  logic write_i,
  input  logic slow_sel_i,
  input  logic launch_ok_i,
  input  logic wrap_i,
  output logic slot_valid_o,
  output logic slot_write_o,
  output logic done_o
);
  psb_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      slot_valid_o <= 1'b0;
      slot_write_o <= 1'b0;
      done_o       <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          // the completion clock never opens a new request
          if (strobe_i && slow_sel_i && !done_o) begin
            slot_write_o <= write_i;
            if (launch_ok_i) begin
              slot_valid_o <= 1'b1;
              state_q      <= ST_ACT;
            end else begin
              state_q      <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (!strobe_i) begin
            state_q <= ST_IDLE;
          end else if (launch_ok_i) begin
            slot_valid_o <= 1'b1;
            state_q      <= ST_ACT;
          end
        end
        ST_ACT: begin
          if (wrap_i) begin
            slot_valid_o <= 1'b0;
            done_o       <= 1'b1;
            state_q      <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/periph_bus_adapter.sv
module periph_bus_adapter #(
  parameter int DIV   = 10,
  parameter int HIGH  = 4,
  parameter int SETUP = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_i,
  input  logic write_i,
  input  logic slow_sel_i,
  output logic sclk_o,
  output logic slot_valid_o,
  output logic slot_write_o,
  output logic xfer_done_o
);
  logic launch_ok;
  logic wrap;

  psb_clkdiv #(
    .DIV  (DIV),
    .HIGH (HIGH),
    .SETUP(SETUP)
  ) u_div (
    .clk        (clk),
    .rst        (rst),
    .sclk_o     (sclk_o),
    .launch_ok_o(launch_ok),
    .wrap_o     (wrap)
  );

  psb_slot_ctl u_ctl (
    .clk         (clk),
    .rst         (rst),
    .strobe_i    (strobe_i),
    .write_i     (write_i),
    .slow_sel_i  (slow_sel_i),
    .launch_ok_i (launch_ok),
    .wrap_i      (wrap),
    .slot_valid_o(slot_valid_o),
    .slot_write_o(slot_write_o),
    .done_o      (xfer_done_o)
  );
endmodule

// File: rtl/psb_checker.sv
module psb_checker #(
  parameter int DIV  = 10,
  parameter int HIGH = 4
) (
  input logic clk,
  input logic rst,
  input logic sclk,
  input logic slot_valid,
  input logic slot_write,
  input logic done
);
  localparam int LOW = DIV - HIGH;
  logic [7:0] hi_run;
  logic [7:0] lo_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_run <= '0;
      lo_run <= '0;
    end else begin
      hi_run <= sclk ? hi_run + 8'd1 : 8'd0;
      lo_run <= sclk ? 8'd0 : lo_run + 8'd1;
    end
  end

  assert_high_len_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk) |-> hi_run == 8'(HIGH));
  assert_low_len_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> lo_run == 8'(LOW));
  assert_setup_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(slot_valid) |-> !sclk ##1 !sclk);
  assert_done_edge_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> ($fell(sclk) && $fell(slot_valid)));
  assert_release_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(slot_valid) |-> done);
  assert_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_dir_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (slot_valid && $past(slot_valid)) |-> $stable(slot_write));
endmodule

bind periph_bus_adapter psb_checker #(.DIV(DIV), .HIGH(HIGH)) u_psb_chk (
  .clk       (clk),
  .rst       (rst),
  .sclk      (sclk_o),
  .slot_valid(slot_valid_o),
  .slot_write(slot_write_o),
  .done      (xfer_done_o)
);

// File: tb/periph_bus_adapter_bench.sv
`timescale 1ns/1ps
module periph_bus_adapter_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strobe = 1'b0, wr = 1'b0, sel = 1'b0;
  logic sclk, svalid, swrite, sdone;

  always #4 clk = ~clk;

  periph_bus_adapter u_periph_bus_adapter (
    .clk(clk), .rst(rst), .strobe_i(strobe), .write_i(wr), .slow_sel_i(sel),
    .sclk_o(sclk), .slot_valid_o(svalid), .slot_write_o(swrite), .xfer_done_o(sdone)
  );

  int total = 0, fails = 0, cyc = 0;
  bit finished = 0;
  // reference model of the current clock, built from the requirements
  int ph = 0, m_st = 0;
  bit m_en = 0, m_vma = 0, m_done = 0, m_wr = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  // apply inputs for the current clock, advance one clock, compare
  task automatic step(input bit s, input bit sl, input bit w);
    int nph, nst;
    bit nvma, ndone, nwr, launch;
    strobe = s; sel = sl; wr = w;
    nph = (ph == 9) ? 0 : ph + 1;
    launch = (ph <= 3);
    nvma = m_vma; ndone = 0; nwr = m_wr; nst = m_st;
    case (m_st)
      0: if (s && sl && !m_done) begin
           nwr = w;
           if (launch) begin nvma = 1; nst = 2; end else nst = 1;
         end
      1: if (!s) nst = 0;
         else if (launch) begin nvma = 1; nst = 2; end
      default: if (ph == 9) begin nvma = 0; ndone = 1; nst = 0; end
    endcase
    @(negedge clk);
    cyc++;
    ph = nph; m_en = (nph >= 6); m_vma = nvma; m_done = ndone; m_wr = nwr; m_st = nst;
    chk(sclk == m_en, "R1 sclk", sclk, m_en);
    chk(svalid == m_vma, "R4 slot_valid", svalid, m_vma);
    chk(sdone == m_done, "R5 done", sdone, m_done);
    if (m_vma) chk(swrite == m_wr, "R7 slot_write", swrite, m_wr);
  endtask

  task automatic idle_to(input int p);
    while (ph != p) step(0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", cyc, 0);
    summary();
  end

  initial begin
    int n, first, d1, d2;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R2: reset state and first rise after 6 clocks
    chk(!sclk && !svalid && !sdone, "R2 reset outputs",
        {29'd0, sclk, svalid, sdone}, 0);
    n = 0;
    while (!sclk && n < 20) begin step(0, 0, 0); n++; end
    chk(n == 6, "R2 first sclk rise", n, 6);

    // R3: strobe without slow select
    n = 0;
    for (int i = 0; i < 30; i++) begin step(1, 0, 1); n += svalid; end
    chk(n == 0, "R3 no select no slot", n, 0);

    // R4/R5: accept in phase 3 -> slot at phase 4, done at phase 0
    idle_to(3);
    step(1, 1, 0);
    chk(svalid && ph == 4, "R4 early launch phase", ph, 4);
    n = 1;
    while (!sdone && n < 30) begin step(1, 1, 0); n += svalid; end
    chk(sdone && ph == 0, "R5 done phase", ph, 0);
    chk(n == 6, "R5 slot length", n, 6);

    // R4/R7: accept in phase 4 with write, flip write while waiting
    step(0, 0, 0);
    idle_to(4);
    step(1, 1, 1);
    n = 0;
    while (!svalid && n < 30) begin step(1, 1, 0); n++; end
    chk(ph == 1, "R4 late launch next period", ph, 1);
    chk(swrite == 1'b1, "R7 captured write", swrite, 1);
    while (!sdone && n < 60) begin step(1, 1, 0); n++; end

    // R8: drop in done clock, re-request at phase 1
    step(0, 0, 0);
    first = cyc;
    step(1, 1, 1);
    n = 0;
    while (!sdone && n < 30) begin step(1, 1, 1); n++; end
    d1 = cyc;
    step(0, 0, 0);
    step(1, 1, 0);
    n = 0;
    while (!sdone && n < 30) begin step(1, 1, 0); n++; end
    d2 = cyc;
    chk(d2 - d1 == 10, "R8 back-to-back spacing", d2 - d1, 10);
    chk(first > 0, "R8 sequence ran", first, 1);

    // R9: strobe held during the done clock only
    step(1, 1, 1);
    n = 0;
    for (int i = 0; i < 15; i++) begin step(0, 0, 0); n += svalid; end
    chk(n == 0, "R9 no restart on done clock", n, 0);

    // R6: accepted in phase 5, strobe dropped before launch
    idle_to(5);
    step(1, 1, 0);
    n = 0;
    for (int i = 0; i < 20; i++) begin step(0, 1, 0); n += svalid + sdone; end
    chk(n == 0, "R6 abandoned request", n, 0);

    // random mix, compared every clock against the model
    for (int i = 0; i < 4000; i++)
      step(($urandom % 4) != 0, ($urandom % 3) != 0, $urandom % 2);

    summary();
  end
endmodule